// File: doc/BRIEF.md
# Counter-Ramp Conversion Sequencer

This block sequences a counter-ramp analog-to-digital conversion. A start request clears an internal code counter and begins a ramp that adds one to the code on every clock. The code leaves the block on a parallel bus that feeds an external DAC. An external comparator reports when the DAC voltage has risen above the analog input. The block then stops the ramp, keeps the code at which the comparator tripped as the conversion result and raises a one-clock completion pulse.

Every conversion begins again from code zero, so its length depends on the input level. A small input finishes in a few clocks. An input at or above full scale uses the whole ramp. If the code reaches all ones and the comparator has not tripped, the ramp stops, the result reads all ones and an overflow flag is set.

The comparator's active level is a parameter. With the default, a high level means the DAC output exceeds the input.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: An active-low synchronous reset forces the sequencer idle. After the reset clock edge, the DAC code, the result, the completion pulse and the overflow flag all read zero.
- R2: A start sampled high on a clock edge, in any state, sets the DAC code to zero at that edge and begins a ramp. Start takes priority over a comparator trip seen at the same edge.
- R3: While ramping with no trip and no start, the DAC code increases by exactly one per clock.
- R4: A comparator trip sampled while ramping at code k stops the ramp, and the result becomes k. For an input level L, modelled as a trip when the code exceeds L, done is high in the cycle that begins L+2 clock edges after the start edge, with result L+1 and overflow 0. This includes L = 2^W-2, which gives result 2^W-1 with no overflow.
- R5: The completion pulse is high for exactly one clock per conversion. The result and the overflow flag then hold until the next conversion completes.
- R6: If the code reaches 2^W-1 while ramping and no trip occurs there, the ramp stops. The result reads all ones and overflow reads 1, with done high 2^W clock edges after the start edge.
- R7: Outside a ramp (idle, or after completion), comparator activity is ignored. The DAC code, the result and the overflow flag stay unchanged, and done stays 0.
- R8: A start received mid-ramp abandons the current ramp. The code returns to zero and the new conversion takes its full data-dependent length from the new start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request, sampled on each rising edge |
| cmp_above_i | input | 1 | Comparator: DAC output above analog input (active level set by parameter) |
| dac_code_o | output | WIDTH | Current ramp code driving the DAC |
| result_o | output | WIDTH | Code held from the last completed conversion |
| done_o | output | 1 | One-clock completion pulse |
| overflow_o | output | 1 | Last conversion ran to full scale without a trip |

## Verification
The code is registered, so after a start edge it reads zero, and after n further edges it reads n. For a modelled input level L, completion is due L+2 edges after the start edge, or 2^W edges when L is at or above full scale. The bench drives inputs on the falling edge and samples there. It counts falling edges from the start edge to the first done and compares that count, the result and the overflow flag with values its functions compute from L. The cycle after each done is checked for a dropped pulse and held outputs.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RAMP = 2'd1,
      ST_HOLD = 2'd2
   } ramp_state_e;

   typedef enum logic [1:0] {
      CNT_KEEP  = 2'd0,
      CNT_CLEAR = 2'd1,
      CNT_STEP  = 2'd2
   } cnt_op_e;

endpackage

// File: rtl/ramp_adc_counter.sv
module ramp_adc_counter
   import ramp_adc_pkg::*;
#(
   parameter int WIDTH = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cnt_op_e          op_i,
   output logic [WIDTH-1:0] code_o,
   output logic             at_top_o
);

   localparam logic [WIDTH-1:0] CODE_ZERO = '0;
   localparam logic [WIDTH-1:0] CODE_ONE  = WIDTH'(1);

   logic [WIDTH-1:0] code_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q <= CODE_ZERO;
      end else begin
         unique case (op_i)
            CNT_CLEAR: code_q <= CODE_ZERO;
            CNT_STEP:  code_q <= code_q + CODE_ONE;
            default:   code_q <= code_q;
         endcase
      end
   end

   assign code_o   = code_q;
   assign at_top_o = &code_q;

endmodule

// File: rtl/ramp_adc_seq.sv
module ramp_adc_seq
   import ramp_adc_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic        trip_i,
   input  logic        at_top_i,
   output ramp_state_e state_o,
   output cnt_op_e     cnt_op_o,
   output logic        finish_o,
   output logic        ovf_o
);

   ramp_state_e state_q;
   ramp_state_e state_d;

   always_comb begin
      state_d  = state_q;
      cnt_op_o = CNT_KEEP;
      finish_o = 1'b0;
      ovf_o    = 1'b0;
      if (start_i) begin
         state_d  = ST_RAMP;
         cnt_op_o = CNT_CLEAR;
      end else if (state_q == ST_RAMP) begin
         if (trip_i) begin
            state_d  = ST_HOLD;
            finish_o = 1'b1;
         end else if (at_top_i) begin
            state_d  = ST_HOLD;
            finish_o = 1'b1;
            ovf_o    = 1'b1;
         end else begin
            cnt_op_o = CNT_STEP;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   assign state_o = state_q;

endmodule

// File: rtl/ramp_adc_capture.sv
module ramp_adc_capture #(
   parameter int WIDTH = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             finish_i,
   input  logic             ovf_i,
   input  logic [WIDTH-1:0] code_i,
   output logic [WIDTH-1:0] result_o,
   output logic             done_o,
   output logic             overflow_o
);

   localparam logic [WIDTH-1:0] FULL_SCALE = '1;

   logic [WIDTH-1:0] result_q;
   logic             done_q;
   logic             ovf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_q <= '0;
         done_q   <= 1'b0;
         ovf_q    <= 1'b0;
      end else begin
         done_q <= finish_i;
         if (finish_i) begin
            result_q <= ovf_i ? FULL_SCALE : code_i;
            ovf_q    <= ovf_i;
         end
      end
   end

   assign result_o   = result_q;
   assign done_o     = done_q;
   assign overflow_o = ovf_q;

endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl
   import ramp_adc_pkg::*;
#(
   parameter int WIDTH           = 6,
   parameter bit CMP_ACTIVE_HIGH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             cmp_above_i,
   output logic [WIDTH-1:0] dac_code_o,
   output logic [WIDTH-1:0] result_o,
   output logic             done_o,
   output logic             overflow_o
);

   localparam int MIN_WIDTH = 2;
   localparam int MAX_WIDTH = 24;

   initial begin
      if (WIDTH < MIN_WIDTH || WIDTH > MAX_WIDTH) begin
         $fatal(1, "ramp_adc_ctrl: WIDTH %0d outside %0d..%0d", WIDTH, MIN_WIDTH, MAX_WIDTH);
      end
   end

   logic        trip_w;
   logic        at_top_w;
   logic        finish_w;
   logic        ovf_w;
   ramp_state_e state_q;
   cnt_op_e     cnt_op_w;

   generate
      if (CMP_ACTIVE_HIGH) begin : g_cmp_high
         assign trip_w = cmp_above_i;
      end else begin : g_cmp_low
         assign trip_w = ~cmp_above_i;
      end
   endgenerate

   ramp_adc_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .trip_i   (trip_w),
      .at_top_i (at_top_w),
      .state_o  (state_q),
      .cnt_op_o (cnt_op_w),
      .finish_o (finish_w),
      .ovf_o    (ovf_w)
   );

   ramp_adc_counter #(.WIDTH(WIDTH)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_i     (cnt_op_w),
      .code_o   (dac_code_o),
      .at_top_o (at_top_w)
   );

   ramp_adc_capture #(.WIDTH(WIDTH)) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .finish_i   (finish_w),
      .ovf_i      (ovf_w),
      .code_i     (dac_code_o),
      .result_o   (result_o),
      .done_o     (done_o),
      .overflow_o (overflow_o)
   );

endmodule

// File: rtl/ramp_adc_ctrl_chk.sv
module ramp_adc_ctrl_chk
   import ramp_adc_pkg::*;
#(
   parameter int WIDTH = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input ramp_state_e      state_i,
   input logic             trip_i,
   input logic [WIDTH-1:0] dac_code_i,
   input logic [WIDTH-1:0] result_i,
   input logic             done_i,
   input logic             overflow_i
);

   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (dac_code_i == '0 && result_i == '0 && !done_i && !overflow_i));

   // R2
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (dac_code_i == '0 && !done_i));

   // R3
   ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ST_RAMP && !start_i && !trip_i && !(&dac_code_i))
      |=> dac_code_i == WIDTH'($past(dac_code_i) + WIDTH'(1)));

   // R4
   done_matches_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |-> result_i == dac_code_i);

   // R5
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> !done_i);

   // R6
   ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overflow_i |-> &result_i);

   // R7
   hold_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ST_HOLD && !start_i)
      |=> (!done_i && $stable(dac_code_i) && $stable(result_i) && $stable(overflow_i)));

endmodule

bind ramp_adc_ctrl ramp_adc_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .state_i    (state_q),
   .trip_i     (trip_w),
   .dac_code_i (dac_code_o),
   .result_i   (result_o),
   .done_i     (done_o),
   .overflow_i (overflow_o)
);

// File: tb/tb_ramp_adc_ctrl.sv
module tb_ramp_adc_ctrl;

   localparam int W    = 6;
   localparam int MAXC = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         ovr_en = 1'b0;
   logic         ovr_val = 1'b0;
   int           level = 0;
   logic         cmp;
   logic [W-1:0] dac_code;
   logic [W-1:0] result;
   logic         done;
   logic         overflow;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   assign cmp = ovr_en ? ovr_val : (int'(dac_code) > level);

   ramp_adc_ctrl #(.WIDTH(W), .CMP_ACTIVE_HIGH(1'b1)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .cmp_above_i (cmp),
      .dac_code_o  (dac_code),
      .result_o    (result),
      .done_o      (done),
      .overflow_o  (overflow)
   );

   function automatic int exp_result(int lv);
      return (lv + 1 > MAXC) ? MAXC : lv + 1;
   endfunction

   function automatic int exp_ovf(int lv);
      return (lv >= MAXC) ? 1 : 0;
   endfunction

   function automatic int exp_lat(int lv);
      return (lv >= MAXC) ? MAXC + 1 : lv + 2;
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   // Waits from just after a start edge until done, checking the ramp each cycle.
   task automatic wait_done(int lv, string req);
      int lat = 0;
      chk("R2", "code after start edge", int'(dac_code), 0);
      do begin
         @(negedge clk);
         lat++;
         if (!done) chk("R3", "ramp code", int'(dac_code), lat);
      end while (!done && lat < MAXC + 20);
      chk(req, "latency", lat, exp_lat(lv));
      chk(req, "result", int'(result), exp_result(lv));
      chk(req, "overflow", int'(overflow), exp_ovf(lv));
      @(negedge clk);
      chk("R5", "done after pulse", int'(done), 0);
      chk("R5", "result held", int'(result), exp_result(lv));
      chk("R5", "overflow held", int'(overflow), exp_ovf(lv));
   endtask

   task automatic run_conv(int lv, string req);
      level = lv;
      pulse_start();
      wait_done(lv, req);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=150000 expected<150000 cycles");
      summary();
      $finish;
   end

   initial begin
      int held_code;
      int held_res;
      int rlv;
      void'($urandom(32'd20240611));

      // R1: reset with the comparator forced active
      ovr_en = 1'b1;
      ovr_val = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1", "code in reset", int'(dac_code), 0);
      chk("R1", "result in reset", int'(result), 0);
      chk("R1", "done in reset", int'(done), 0);
      chk("R1", "overflow in reset", int'(overflow), 0);
      rst_n = 1'b1;

      // R7: comparator toggling while idle
      for (int i = 0; i < 6; i++) begin
         @(negedge clk) ovr_val = ~ovr_val;
      end
      @(negedge clk);
      chk("R7", "idle code", int'(dac_code), 0);
      chk("R7", "idle done", int'(done), 0);
      chk("R7", "idle result", int'(result), 0);
      ovr_en = 1'b0;

      // R4 / R6 directed corners
      run_conv(0, "R4");
      run_conv(5, "R4");
      run_conv(MAXC - 1, "R4");
      run_conv(MAXC, "R6");
      run_conv(MAXC + 7, "R6");

      // R7: comparator activity after completion
      run_conv(12, "R4");
      held_code = int'(dac_code);
      held_res  = int'(result);
      ovr_en = 1'b1;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk) ovr_val = ~ovr_val;
         chk("R7", "hold done", int'(done), 0);
      end
      @(negedge clk);
      chk("R7", "hold code", int'(dac_code), held_code);
      chk("R7", "hold result", int'(result), held_res);
      chk("R7", "hold overflow", int'(overflow), 0);
      ovr_en = 1'b0;

      // R8: restart mid-ramp
      level = 40;
      pulse_start();
      repeat (10) @(negedge clk);
      chk("R8", "code before restart", int'(dac_code), 10);
      pulse_start();
      wait_done(40, "R8");

      // R2: start wins over a simultaneous trip
      level = 50;
      pulse_start();
      repeat (5) @(negedge clk);
      ovr_en = 1'b1;
      ovr_val = 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      ovr_en = 1'b0;
      chk("R2", "done when start meets trip", int'(done), 0);
      wait_done(50, "R2");

      // Random levels
      for (int i = 0; i < 20; i++) begin
         rlv = int'($urandom_range(0, MAXC + 4));
         run_conv(rlv, (rlv >= MAXC) ? "R6" : "R4");
      end

      summary();
      $finish;
   end

endmodule